// File: doc/BRIEF.md
# Queued Asynchronous Serial Transceiver with Receiver Wakeup

This block is a non-return-to-zero asynchronous serial port with start and stop bits. Each direction has its own enable and its own 16-entry queue in front of a shift register. A word written into the transmit queue waits there until the transmitter is enabled and idle. A received frame is stored in the receive queue along with its data, parity error, framing error and noise flags. The host reads the receive queue in show-ahead order.

A frame holds 8 or 9 data bits, sent least significant bit first. An optional even or odd parity bit follows the data. The bit rate is the system clock divided by 32 times a 13-bit divisor, and a divisor of zero stops all serial activity. The receiver oversamples at 16 times the bit rate. It takes a two-of-three vote from three samples in the middle of each bit.

The receiver can be put to sleep so that the host is not disturbed by traffic meant for other nodes. Sleep ends in one of two ways, chosen by a mode input. In the first, a frame whose top data bit is 1 wakes the receiver and is kept. In the second, the line stays at mark for a whole frame time. A single-wire mode connects the receiver to the transmitter's own output line, for half-duplex use.

Top module: `uart_wake_q`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then one high stop bit. Each bit lasts 32 times `div` clock cycles.
- R2: With `nine_bit` set a frame carries 9 data bits, and otherwise 8. In 8-bit mode bit 8 of the data output reads 0.
- R3: With `par_en` set, a parity bit follows the data. The parity bit makes the count of ones in data plus parity even when `par_odd` is 0, and odd when it is 1. A received frame whose parity bit disagrees has `rx_perr` set in its entry.
- R4: While `tx_en` is low, queued words stay in the queue and `txd` stays high. While `rx_en` is low, line activity stores nothing.
- R5: Each queue holds 16 words, and words leave in the order they were written. `tx_full` is high when the transmit queue holds 16 words, and a write while it is full is ignored.
- R6: A frame that completes while the receive queue is full is dropped. `rx_overrun` is then set and stays set until the next read of the receive queue.
- R7: A frame whose stop bit votes low is stored with `rx_ferr` set.
- R8: If the three samples of any bit in a frame disagree, the frame is stored with `rx_noise` set, and the data holds the majority values.
- R9: A `sleep_req` pulse sets `rx_asleep`. While asleep with `wake_addr_mode` set, frames whose top data bit (bit 7, or bit 8 in 9-bit mode) is 0 are dropped. The first frame whose top bit is 1 clears `rx_asleep` and is stored.
- R10: While asleep with `wake_addr_mode` clear, all frames are dropped. `rx_asleep` clears once the line has been high for one full frame time without a start bit.
- R11: With `single_wire` set, the receiver listens to `txd` and ignores `rxd`.
- R12: With `div` equal to 0, no bit timing advances: `txd` holds its level and queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | 13 | Bit-rate divisor; 0 stops bit timing |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wake_addr_mode | input | 1 | 1 wakes on a marked frame, 0 wakes on an idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| single_wire | input | 1 | Receiver listens to txd |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_wdata | input | 9 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_active | output | 1 | Transmit queue or shifter holds a word |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read strobe for the receive queue |
| rx_avail | output | 1 | Receive queue not empty |
| rx_rdata | output | 9 | Data of the oldest received entry |
| rx_perr | output | 1 | Parity error flag of the oldest entry |
| rx_ferr | output | 1 | Framing error flag of the oldest entry |
| rx_noise | output | 1 | Noise flag of the oldest entry |
| rx_overrun | output | 1 | A frame was dropped because the queue was full |
| rx_asleep | output | 1 | Receiver is in wakeup mode |

## Verification
A wrong bit counter or sampling phase in the receiver shows up at the read port one frame time later. It appears as a changed data word, a false framing or noise flag, or a missing entry, so every queue entry is compared with the word the bench expects, in order. A wrong queue pointer shows as entries out of order or repeated, and appears as soon as the entries are read. A wrong sleep state shows as an entry that should not exist, or a missing one, after the frame that should have been dropped or should have woken the receiver. `rx_asleep` is checked directly at those points. A wrong transmit shifter is caught by decoding `txd` at each mid-bit point of one frame.

// File: rtl/uart_wq_pkg.sv
package uart_wq_pkg;
   localparam int MAXD = 9;

   typedef struct packed {
      logic            noise;
      logic            ferr;
      logic            perr;
      logic [MAXD-1:0] data;
   } rx_word_t;

   typedef enum logic {RX_IDLE, RX_BITS} rx_st_t;

   // Bits per frame: start + data (8/9) + optional parity + stop
   function automatic logic [3:0] frame_bits(input logic nine, input logic pen);
      return 4'd10 + {3'd0, nine} + {3'd0, pen};
   endfunction
endpackage

// File: rtl/uart_wq_fifo.sv
module uart_wq_fifo #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("queue depth must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         unique case ({push, pop})
            2'b10:   cnt <= cnt + (AW+1)'(1);
            2'b01:   cnt <= cnt - (AW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/uart_wq_baud.sv
module uart_wq_baud #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   // 16x oversampling tick: one tick every 2*div clocks
   logic [DIV_W:0] cnt, lim;

   assign lim  = {div, 1'b0} - (DIV_W+1)'(1);
   assign tick = (div != '0) && (cnt == lim) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt <= '0;
      else if (restart || div == '0 || tick)   cnt <= '0;
      else                                     cnt <= cnt + (DIV_W+1)'(1);
   end
endmodule

// File: rtl/uart_wq_tx.sv
module uart_wq_tx
   import uart_wq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            en,
   input  logic            nine,
   input  logic            pen,
   input  logic            podd,
   input  logic [MAXD-1:0] qdata,
   input  logic            qempty,
   output logic            qpop,
   output logic            txd,
   output logic            busy
);
   logic [11:0] sh, frame;
   logic [3:0]  left, phase;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      if (nine) begin
         frame[9:1] = qdata;
         if (pen) frame[10] = ^qdata ^ podd;
      end else begin
         frame[8:1] = qdata[7:0];
         if (pen) frame[9] = ^qdata[7:0] ^ podd;
      end
   end

   assign qpop = tick && en && !qempty && !busy;
   assign txd  = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '1;
         left  <= '0;
         phase <= '0;
         busy  <= 1'b0;
      end else if (qpop) begin
         sh    <= frame;
         left  <= frame_bits(nine, pen);
         phase <= '0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         phase <= phase + 4'd1;
         if (phase == 4'd15) begin
            sh   <= {1'b1, sh[11:1]};
            left <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end
      end
   end

   a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_wq_rx.sv
module uart_wq_rx
   import uart_wq_pkg::*;
#(
   parameter int SYNC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     line_in,
   input  logic     tick,
   input  logic     en,
   input  logic     nine,
   input  logic     pen,
   input  logic     podd,
   input  logic     wake_addr,
   input  logic     sleep_req,
   input  logic     full,
   output logic     restart,
   output logic     push,
   output logic     ovr,
   output logic     asleep,
   output rx_word_t word
);
   initial begin
      assert (SYNC >= 1) else $error("synchronizer needs at least one stage");
   end

   logic [SYNC-1:0] sync;
   logic            line;

   generate
      if (SYNC == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync <= '1; else sync <= line_in;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync <= '1; else sync <= {sync[SYNC-2:0], line_in};
      end
   endgenerate
   assign line = sync[SYNC-1];

   rx_st_t          st;
   logic [3:0]      phase, idx, nbits;
   logic            s7, s8, s9, noisy, maj, nz, resolve, done, accept, msb, pbit;
   logic [11:0]     bits;
   logic [MAXD-1:0] d;
   logic [7:0]      idle_cnt, thr;

   assign nbits   = frame_bits(nine, pen);
   assign thr     = {nbits, 4'b0000};
   assign maj     = (s7 & s8) | (s7 & s9) | (s8 & s9);
   assign nz      = !((s7 == s8) && (s8 == s9));
   assign resolve = en && tick && st == RX_BITS && phase == 4'd15;
   assign done    = resolve && idx == nbits - 4'd1;
   assign d       = nine ? bits[9:1] : {1'b0, bits[8:1]};
   assign pbit    = nine ? bits[10] : bits[9];
   assign msb     = nine ? d[8] : d[7];
   assign accept  = !asleep || (wake_addr && msb);
   assign push    = done && accept && !full;
   assign ovr     = done && accept && full;
   assign restart = en && st == RX_IDLE && !line;
   assign word    = '{noise: noisy | nz, ferr: !maj,
                      perr: pen && (pbit != (^d ^ podd)), data: d};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; phase <= '0; idx <= '0; bits <= '0;
         s7 <= 1'b1; s8 <= 1'b1; s9 <= 1'b1; noisy <= 1'b0;
      end else if (!en) begin
         st <= RX_IDLE;
      end else if (restart) begin
         st <= RX_BITS; phase <= '0; idx <= '0; noisy <= 1'b0;
      end else if (st == RX_BITS && tick) begin
         phase <= phase + 4'd1;
         if (phase == 4'd7) s7 <= line;
         if (phase == 4'd8) s8 <= line;
         if (phase == 4'd9) s9 <= line;
         if (resolve) begin
            if (idx == 4'd0 && maj) begin
               st <= RX_IDLE;                 // false start
            end else begin
               bits[idx] <= maj;
               noisy     <= noisy | nz;
               if (done) st <= RX_IDLE;
               else      idx <= idx + 4'd1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            idle_cnt <= '0;
      else if (!en || st != RX_IDLE || !line || sleep_req)   idle_cnt <= '0;
      else if (tick && idle_cnt != 8'hFF)                    idle_cnt <= idle_cnt + 8'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     asleep <= 1'b0;
      else if (sleep_req)                             asleep <= 1'b1;
      else if (done && asleep && wake_addr && msb)    asleep <= 1'b0;
      else if (asleep && !wake_addr && idle_cnt >= thr) asleep <= 1'b0;
   end

   // R9 / R10: a sleeping receiver in idle-wake mode stores nothing
   a_r10_sleep_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (done && asleep && !wake_addr) |-> !push);
   a_r9_wake_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (done && asleep && wake_addr && msb && !full) |-> push);
endmodule

// File: rtl/uart_wake_q.sv
module uart_wake_q
   import uart_wq_pkg::*;
#(
   parameter int DIV_W  = 13,
   parameter int QDEPTH = 16,
   parameter int SYNC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             nine_bit,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             wake_addr_mode,
   input  logic             sleep_req,
   input  logic             single_wire,
   input  logic             tx_wr,
   input  logic [MAXD-1:0]  tx_wdata,
   output logic             tx_full,
   output logic             tx_active,
   output logic             txd,
   input  logic             rxd,
   input  logic             rx_rd,
   output logic             rx_avail,
   output logic [MAXD-1:0]  rx_rdata,
   output logic             rx_perr,
   output logic             rx_ferr,
   output logic             rx_noise,
   output logic             rx_overrun,
   output logic             rx_asleep
);
   localparam int RXW = $bits(rx_word_t);

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 24) else $error("divisor width out of range");
   end

   logic            tx_tick, rx_tick, rx_restart;
   logic            tx_push, tx_pop, tx_empty, tx_busy;
   logic [MAXD-1:0] tx_qdata;
   logic            rx_push, rx_pop, rx_empty, rx_full, rx_ovr, rx_line;
   rx_word_t        rx_word, rx_head;
   logic [RXW-1:0]  rx_head_raw;

   assign tx_push = tx_wr && !tx_full;
   assign rx_line = single_wire ? txd : rxd;
   assign rx_pop  = rx_rd && !rx_empty;

   uart_wq_baud #(.DIV_W(DIV_W)) u_tx_baud (
      .clk(clk), .rst_n(rst_n), .div(div), .restart(1'b0), .tick(tx_tick));

   uart_wq_baud #(.DIV_W(DIV_W)) u_rx_baud (
      .clk(clk), .rst_n(rst_n), .div(div), .restart(rx_restart), .tick(rx_tick));

   uart_wq_fifo #(.WIDTH(MAXD), .DEPTH(QDEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_qdata), .empty(tx_empty), .full(tx_full));

   uart_wq_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tx_tick), .en(tx_en), .nine(nine_bit),
      .pen(par_en), .podd(par_odd), .qdata(tx_qdata), .qempty(tx_empty),
      .qpop(tx_pop), .txd(txd), .busy(tx_busy));

   uart_wq_rx #(.SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .line_in(rx_line), .tick(rx_tick), .en(rx_en),
      .nine(nine_bit), .pen(par_en), .podd(par_odd), .wake_addr(wake_addr_mode),
      .sleep_req(sleep_req), .full(rx_full), .restart(rx_restart), .push(rx_push),
      .ovr(rx_ovr), .asleep(rx_asleep), .word(rx_word));

   uart_wq_fifo #(.WIDTH(RXW), .DEPTH(QDEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
      .rdata(rx_head_raw), .empty(rx_empty), .full(rx_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_overrun <= 1'b0;
      else if (rx_ovr) rx_overrun <= 1'b1;
      else if (rx_pop) rx_overrun <= 1'b0;
   end

   assign rx_head   = rx_word_t'(rx_head_raw);
   assign rx_avail  = !rx_empty;
   assign rx_rdata  = rx_head.data;
   assign rx_perr   = rx_head.perr;
   assign rx_ferr   = rx_head.ferr;
   assign rx_noise  = rx_head.noise;
   assign tx_active = tx_busy || !tx_empty;

   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && !rx_pop) |=> rx_overrun);
   a_r12_frozen_line: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0 && $past(div == '0)) |-> $stable(txd));
endmodule

// File: tb/uart_wake_q_test.sv
module uart_wake_q_test;
   localparam int BITCLK = 128;   // 32 * div with div = 4

   logic clk = 1'b0;
   always #2.5 clk = ~clk;        // 200 MHz

   logic        rst_n, tx_en, rx_en, nine_bit, par_en, par_odd, wake_addr_mode;
   logic        sleep_req, single_wire, tx_wr, rxd, rx_rd;
   logic [12:0] div;
   logic [8:0]  tx_wdata, rx_rdata;
   logic        tx_full, tx_active, txd, rx_avail, rx_perr, rx_ferr, rx_noise;
   logic        rx_overrun, rx_asleep;

   uart_wake_q uut (
      .clk(clk), .rst_n(rst_n), .div(div), .tx_en(tx_en), .rx_en(rx_en),
      .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
      .wake_addr_mode(wake_addr_mode), .sleep_req(sleep_req),
      .single_wire(single_wire), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .tx_full(tx_full), .tx_active(tx_active), .txd(txd), .rxd(rxd),
      .rx_rd(rx_rd), .rx_avail(rx_avail), .rx_rdata(rx_rdata), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_noise(rx_noise), .rx_overrun(rx_overrun),
      .rx_asleep(rx_asleep));

   int          n_chk = 0, n_fail = 0;
   bit          mon_on = 1'b1;
   logic [11:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // expected entry = {noise, ferr, perr, data}
   task automatic expect_word(input logic [8:0] d, input logic [2:0] flg, input string tag);
      exp_q.push_back({flg, d});
      tag_q.push_back(tag);
   endtask

   // Monitor: pop and compare every entry the receive queue presents
   initial begin
      rx_rd = 1'b0;
      forever begin
         @(negedge clk);
         rx_rd = 1'b0;
         if (mon_on && rx_avail) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 R9 R10", "unexpected entry",
                   int'({rx_noise, rx_ferr, rx_perr, rx_rdata}), 0);
            end else begin
               logic [11:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({rx_noise, rx_ferr, rx_perr, rx_rdata} == e, t, "received entry",
                   int'({rx_noise, rx_ferr, rx_perr, rx_rdata}), int'(e));
            end
            rx_rd = 1'b1;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      summary();
   end

   task automatic push_tx(input logic [8:0] d);
      @(negedge clk);
      tx_wr = 1'b1; tx_wdata = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   function automatic logic [11:0] build(input logic [8:0] d);
      logic [11:0] f;
      f = '1; f[0] = 1'b0;
      if (nine_bit) begin
         f[9:1] = d;
         if (par_en) f[10] = ^d ^ par_odd;
      end else begin
         f[8:1] = d[7:0];
         if (par_en) f[9] = ^d[7:0] ^ par_odd;
      end
      return f;
   endfunction

   // Drive one frame on rxd, then one bit time of mark
   task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                             input int glitch);
      logic [11:0] f;
      int          len;
      f   = build(d);
      len = 10 + int'(nine_bit) + int'(par_en);
      if (bad_par)  f[len-2] = ~f[len-2];
      if (bad_stop) f[len-1] = 1'b0;
      for (int b = 0; b < len; b++) begin
         for (int c = 0; c < BITCLK; c++) begin
            rxd = (b == glitch && c >= 76 && c < 86) ? ~f[b] : f[b];
            @(negedge clk);
         end
      end
      rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic wait_drain(input string req);
      for (int i = 0; i < 40000 && (exp_q.size() != 0 || tx_active); i++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, req, "expected entries left", exp_q.size(), 0);
   endtask

   task automatic pulse_sleep();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
   endtask

   initial begin
      logic [9:0] seen;
      int         lows;
      rst_n = 1'b0; div = 13'd4; tx_en = 1'b0; rx_en = 1'b1; nine_bit = 1'b0;
      par_en = 1'b0; par_odd = 1'b0; wake_addr_mode = 1'b0; sleep_req = 1'b0;
      single_wire = 1'b0; tx_wr = 1'b0; tx_wdata = '0; rxd = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1", "reset txd", txd, 1);
      chk(!rx_avail && !tx_full && !tx_active && !rx_asleep && !rx_overrun, "R5",
          "reset status", {rx_avail, tx_full, tx_active, rx_asleep, rx_overrun}, 0);

      // R1: decode one frame at mid-bit points
      tx_en = 1'b1;
      push_tx(9'h0A5);
      for (int i = 0; i < 2000 && txd; i++) @(negedge clk);
      repeat (BITCLK / 2) @(negedge clk);
      for (int b = 0; b < 10; b++) begin
         seen[b] = txd;
         repeat (BITCLK) @(negedge clk);
      end
      chk(seen == {1'b1, 8'hA5, 1'b0}, "R1", "txd frame bits", seen, {1'b1, 8'hA5, 1'b0});
      wait_drain("R1");

      // R4, R5, R11: fill disabled transmitter, then loop back
      tx_en = 1'b0; single_wire = 1'b1; rxd = 1'b0;   // rxd ignored in single-wire mode
      for (int i = 0; i < 16; i++) begin
         push_tx(9'((i * 37 + 5) & 8'hFF));
         expect_word(9'((i * 37 + 5) & 8'hFF), 3'b000, "R5 R11");
      end
      chk(tx_full == 1'b1, "R5", "tx_full after 16 writes", tx_full, 1);
      push_tx(9'h0EE);                                  // ignored while full
      lows = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!txd) lows++;
      end
      chk(lows == 0, "R4", "txd low cycles while disabled", lows, 0);
      tx_en = 1'b1;
      wait_drain("R5");

      // R2, R3: 9-bit even parity and 8-bit odd parity loopback
      nine_bit = 1'b1; par_en = 1'b1; par_odd = 1'b0;
      expect_word(9'h1A5, 3'b000, "R2"); push_tx(9'h1A5);
      expect_word(9'h0F1, 3'b000, "R3"); push_tx(9'h0F1);
      wait_drain("R2");
      nine_bit = 1'b0; par_odd = 1'b1;
      expect_word(9'h05A, 3'b000, "R3"); push_tx(9'h05A);
      expect_word(9'h000, 3'b000, "R3"); push_tx(9'h000);
      wait_drain("R3");

      // R3, R7, R8: errors injected on rxd
      single_wire = 1'b0; rxd = 1'b1; par_odd = 1'b0;
      repeat (BITCLK) @(negedge clk);
      expect_word(9'h03C, 3'b001, "R3"); send_frame(9'h03C, 1'b1, 1'b0, -1);
      expect_word(9'h03C, 3'b000, "R3"); send_frame(9'h03C, 1'b0, 1'b0, -1);
      par_en = 1'b0;
      expect_word(9'h055, 3'b010, "R7"); send_frame(9'h055, 1'b0, 1'b1, -1);
      expect_word(9'h066, 3'b100, "R8"); send_frame(9'h066, 1'b0, 1'b0, 3);
      wait_drain("R8");

      // R4: receiver disabled
      rx_en = 1'b0;
      send_frame(9'h077, 1'b0, 1'b0, -1);
      chk(rx_avail == 1'b0, "R4", "entry with rx disabled", rx_avail, 0);
      rx_en = 1'b1;

      // R6: overrun
      mon_on = 1'b0;
      for (int i = 0; i < 17; i++) begin
         if (i < 16) expect_word(9'(8'h40 + i), 3'b000, "R6");
         send_frame(9'(8'h40 + i), 1'b0, 1'b0, -1);
      end
      chk(rx_overrun == 1'b1, "R6", "overrun after 17 frames", rx_overrun, 1);
      mon_on = 1'b1;
      wait_drain("R6");
      chk(rx_overrun == 1'b0, "R6", "overrun after reads", rx_overrun, 0);

      // R9: address-mark wakeup
      wake_addr_mode = 1'b1;
      pulse_sleep();
      chk(rx_asleep == 1'b1, "R9", "asleep after request", rx_asleep, 1);
      send_frame(9'h012, 1'b0, 1'b0, -1);
      chk(rx_avail == 1'b0 && rx_asleep == 1'b1, "R9", "unmarked frame dropped",
          {rx_avail, rx_asleep}, 1);
      expect_word(9'h085, 3'b000, "R9"); send_frame(9'h085, 1'b0, 1'b0, -1);
      chk(rx_asleep == 1'b0, "R9", "awake after marked frame", rx_asleep, 0);
      expect_word(9'h013, 3'b000, "R9"); send_frame(9'h013, 1'b0, 1'b0, -1);
      wait_drain("R9");

      // R10: idle-line wakeup
      wake_addr_mode = 1'b0;
      pulse_sleep();
      send_frame(9'h0A1, 1'b0, 1'b0, -1);
      chk(rx_avail == 1'b0 && rx_asleep == 1'b1, "R10", "frame dropped while asleep",
          {rx_avail, rx_asleep}, 1);
      repeat (12 * BITCLK) @(negedge clk);
      chk(rx_asleep == 1'b0, "R10", "awake after idle frame time", rx_asleep, 0);
      expect_word(9'h022, 3'b000, "R10"); send_frame(9'h022, 1'b0, 1'b0, -1);
      wait_drain("R10");

      // R12: zero divisor freezes timing
      div = 13'd0; single_wire = 1'b1;
      expect_word(9'h03E, 3'b000, "R12"); push_tx(9'h03E);
      lows = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (!txd) lows++;
      end
      chk(lows == 0, "R12", "txd low cycles with div 0", lows, 0);
      chk(tx_active == 1'b1, "R12", "word still queued", tx_active, 1);
      div = 13'd4;
      wait_drain("R12");

      summary();
   end
endmodule